// File: doc/BRIEF.md
# Bit-6 Address Swizzle Unit

This block rewrites bit 6 of a CPU byte address that falls inside a tiled graphics surface. In dual-channel interleaved memory, the graphics engine picks the memory channel of a tiled surface by mixing several higher address bits into bit 6. A CPU that writes the same surface must apply the same mix, or it lands on the wrong channel. The unit XORs a chosen set of higher address bits (9, 10, 11 and 17) into bit 6. The set is taken from a programmed swizzle mode, with one mode for X-tiled surfaces and another for Y-tiled ones. Untiled accesses are never changed.

A request enters through a valid/ready port. It comes out one clock later through a registered valid/ready port, together with the tiling the access was actually handled as and the swizzle mode as software sees it. The software view never names bit 17, because bit 17 depends on physical page placement. Instead it reports the same mode without that bit. A programmed mode of "unknown" makes a tiled access fall back to untiled. A configuration write port loads both modes at once. Their software-visible forms are always presented on two status outputs.

Top module: `bit6_swizzle_unit`

## Requirements
- R1: Swizzle mode codes select the bits XORed into bit 6 as follows: 0 none, 1 bit 9, 2 bits 9 and 10, 3 bits 9 and 11, 4 bits 9, 10 and 11, 5 unknown, 6 bits 9 and 17, 7 bits 9, 10 and 17. Output bit 6 is input bit 6 XORed with every selected bit.
- R2: All address bits other than bit 6 reach rsp_addr unchanged.
- R3: Tiling code 0 (untiled) always uses mode 0, whatever is programmed. It reports rsp_tiling 0 and rsp_swz 0.
- R4: Tiling code 1 (X) uses the programmed X mode, and tiling code 2 (Y) uses the programmed Y mode. rsp_tiling repeats the request tiling.
- R5: A tiled request whose selected mode is 5 passes through unswizzled and reports rsp_tiling 0 and rsp_swz 0.
- R6: rsp_swz, cfg_x_vis and cfg_y_vis give the software view of a mode. Codes 6 and 7 become 1 and 2, and every other code is shown unchanged.
- R7: Tiling code 3 sets rsp_err to 1. It passes the address unswizzled and reports rsp_tiling 3 and rsp_swz 0. All other codes give rsp_err 0.
- R8: An accepted request appears on the response port on the next clock edge. req_ready equals (not rsp_valid) or rsp_ready. While rsp_valid is 1 and rsp_ready is 0, the response holds stable.
- R9: Synchronous active-high rst clears rsp_valid and sets both programmed modes to 0.
- R10: cfg_we loads both modes on a clock edge. A request accepted on that same edge still uses the previous modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Load both swizzle modes |
| cfg_x_mode | input | 3 | Mode for X-tiled accesses |
| cfg_y_mode | input | 3 | Mode for Y-tiled accesses |
| cfg_x_vis | output | 3 | Software view of the X mode |
| cfg_y_vis | output | 3 | Software view of the Y mode |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_addr | input | AW | Byte address |
| req_tiling | input | 2 | 0 untiled, 1 X, 2 Y, 3 invalid |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | AW | Swizzled address |
| rsp_tiling | output | 2 | Tiling the access was handled as |
| rsp_swz | output | 3 | Software view of the mode applied |
| rsp_err | output | 1 | Invalid tiling code seen |

## Verification
The unit holds only two mode registers and one response stage. A wrong mode register shows up on cfg_x_vis or cfg_y_vis at once. It also shows up in bit 6 of the very next tiled response that has the affected source bits set. A corrupt response stage shows one cycle after acceptance, either as a changed bit other than bit 6 or as a response that moves while it is stalled. The stimulus therefore sets address bits 9, 10, 11 and 17 in mixed patterns under every mode, so that each missing or extra tap flips bit 6.

// File: rtl/bit6_swizzle_unit.sv
module bit6_swizzle_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_x_mode,
  input  logic [2:0]    cfg_y_mode,
  output logic [2:0]    cfg_x_vis,
  output logic [2:0]    cfg_y_vis,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_tiling,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_addr,
  output logic [1:0]    rsp_tiling,
  output logic [2:0]    rsp_swz,
  output logic          rsp_err
);

  localparam logic [2:0] M_NONE = 3'd0;
  localparam logic [2:0] M_UNK  = 3'd5;
  localparam logic [1:0] T_NONE = 2'd0;
  localparam logic [1:0] T_X    = 2'd1;
  localparam logic [1:0] T_Y    = 2'd2;
  localparam logic [1:0] T_BAD  = 2'd3;

  function automatic logic [2:0] sw_view(input logic [2:0] m);
    case (m)
      3'd6:    return 3'd1;
      3'd7:    return 3'd2;
      default: return m;
    endcase
  endfunction

  logic [2:0] x_mode_q, y_mode_q;
  logic [2:0] sel_mode;
  logic [1:0] eff_tiling;
  logic       bad_tiling;

  always_comb begin
    sel_mode   = M_NONE;
    eff_tiling = req_tiling;
    bad_tiling = 1'b0;
    case (req_tiling)
      T_X:     sel_mode = x_mode_q;
      T_Y:     sel_mode = y_mode_q;
      T_BAD:   bad_tiling = 1'b1;
      default: sel_mode = M_NONE;
    endcase
    if (sel_mode == M_UNK) begin
      sel_mode   = M_NONE;
      eff_tiling = T_NONE;
    end
  end

  logic tap9, tap10, tap11, tap17, flip;
  assign tap9  = sel_mode inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd6, 3'd7};
  assign tap10 = sel_mode inside {3'd2, 3'd4, 3'd7};
  assign tap11 = sel_mode inside {3'd3, 3'd4};
  assign tap17 = sel_mode inside {3'd6, 3'd7};
  assign flip  = (tap9 & req_addr[9]) ^ (tap10 & req_addr[10])
               ^ (tap11 & req_addr[11]) ^ (tap17 & req_addr[17]);

  logic [AW-1:0] new_addr;
  always_comb begin
    new_addr    = req_addr;
    new_addr[6] = req_addr[6] ^ flip;
  end

  logic accept;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign cfg_x_vis = sw_view(x_mode_q);
  assign cfg_y_vis = sw_view(y_mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      x_mode_q   <= M_NONE;
      y_mode_q   <= M_NONE;
      rsp_valid  <= 1'b0;
      rsp_addr   <= '0;
      rsp_tiling <= T_NONE;
      rsp_swz    <= M_NONE;
      rsp_err    <= 1'b0;
    end else begin
      if (cfg_we) begin
        x_mode_q <= cfg_x_mode;
        y_mode_q <= cfg_y_mode;
      end
      if (accept) begin
        rsp_valid  <= 1'b1;
        rsp_addr   <= new_addr;
        rsp_tiling <= eff_tiling;
        rsp_swz    <= sw_view(sel_mode);
        rsp_err    <= bad_tiling;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bit6_swizzle_unit_chk.sv
module bit6_swizzle_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    cfg_x_vis,
  input logic [2:0]    cfg_y_vis,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    req_tiling,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [AW-1:0] rsp_addr,
  input logic [1:0]    rsp_tiling,
  input logic [2:0]    rsp_swz,
  input logic          rsp_err
);

  a_r2_other_bits_kept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=>
      (rsp_addr[AW-1:7] == $past(req_addr[AW-1:7]) && rsp_addr[5:0] == $past(req_addr[5:0])));

  a_r3_untiled_unchanged: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_tiling == 2'd0) |=>
      (rsp_addr == $past(req_addr) && rsp_tiling == 2'd0 && rsp_swz == 3'd0));

  a_r6_bit17_hidden: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_swz != 3'd6 && rsp_swz != 3'd7 && cfg_x_vis < 3'd6 && cfg_y_vis < 3'd6));

  a_r7_bad_tiling_flagged: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_tiling == 2'd3) |=>
      (rsp_err && rsp_addr == $past(req_addr) && rsp_swz == 3'd0));

  a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  a_r8_hold_when_stalled: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_swz)));

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!rsp_valid && cfg_x_vis == 3'd0 && cfg_y_vis == 3'd0));

endmodule

bind bit6_swizzle_unit bit6_swizzle_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .cfg_x_vis(cfg_x_vis), .cfg_y_vis(cfg_y_vis),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .req_tiling(req_tiling), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_addr(rsp_addr), .rsp_tiling(rsp_tiling), .rsp_swz(rsp_swz), .rsp_err(rsp_err)
);

// File: tb/bit6_swizzle_unit_bench.sv
module bit6_swizzle_unit_bench;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_x_mode = '0, cfg_y_mode = '0;
  logic [2:0] cfg_x_vis, cfg_y_vis;
  logic req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_tiling = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [AW-1:0] rsp_addr;
  logic [1:0] rsp_tiling;
  logic [2:0] rsp_swz;
  logic rsp_err;

  int n_tests = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bit6_swizzle_unit #(.AW(AW)) u_bit6_swizzle_unit (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_x_mode(cfg_x_mode), .cfg_y_mode(cfg_y_mode),
    .cfg_x_vis(cfg_x_vis), .cfg_y_vis(cfg_y_vis), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_tiling(req_tiling), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_tiling(rsp_tiling), .rsp_swz(rsp_swz), .rsp_err(rsp_err)
  );

  // {x_mode, y_mode, tiling, addr}
  localparam logic [39:0] VEC [18] = '{
    {3'd4, 3'd4, 2'd0, 32'h0002_0E40},
    {3'd2, 3'd1, 2'd1, 32'h0000_0200},
    {3'd2, 3'd1, 2'd1, 32'h0000_0600},
    {3'd2, 3'd1, 2'd1, 32'h0000_0440},
    {3'd2, 3'd1, 2'd2, 32'h0000_0600},
    {3'd2, 3'd1, 2'd2, 32'h0000_0400},
    {3'd3, 3'd0, 2'd1, 32'h0000_0A00},
    {3'd3, 3'd0, 2'd1, 32'h0000_0800},
    {3'd4, 3'd0, 2'd1, 32'h0000_0E00},
    {3'd4, 3'd0, 2'd1, 32'h0000_0C40},
    {3'd0, 3'd6, 2'd2, 32'h0002_0000},
    {3'd0, 3'd6, 2'd2, 32'h0002_0240},
    {3'd7, 3'd0, 2'd1, 32'h0002_0600},
    {3'd7, 3'd0, 2'd1, 32'h0002_0400},
    {3'd5, 3'd1, 2'd1, 32'h0000_0E00},
    {3'd1, 3'd5, 2'd2, 32'h0002_0E40},
    {3'd4, 3'd4, 2'd3, 32'hFFFF_FFBF},
    {3'd0, 3'd4, 2'd1, 32'hABCD_EE7F}
  };

  // expected {addr, tiling, swz, err} derived from the requirement text
  function automatic logic [37:0] expect_of(input logic [2:0] x, input logic [2:0] y,
                                            input logic [1:0] t, input logic [31:0] a);
    logic [2:0] m;
    logic [1:0] tt;
    logic [31:0] o;
    logic [2:0] v;
    m = (t == 2'd1) ? x : (t == 2'd2) ? y : 3'd0;
    tt = t;
    if (m == 3'd5) begin m = 3'd0; tt = 2'd0; end
    o = a;
    case (m)
      3'd1: o[6] = a[6] ^ a[9];
      3'd2: o[6] = a[6] ^ a[9] ^ a[10];
      3'd3: o[6] = a[6] ^ a[9] ^ a[11];
      3'd4: o[6] = a[6] ^ a[9] ^ a[10] ^ a[11];
      3'd6: o[6] = a[6] ^ a[9] ^ a[17];
      3'd7: o[6] = a[6] ^ a[9] ^ a[10] ^ a[17];
      default: o = a;
    endcase
    v = (m == 3'd6) ? 3'd1 : (m == 3'd7) ? 3'd2 : m;
    return {o, tt, v, (t == 2'd3)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic program_modes(input logic [2:0] x, input logic [2:0] y);
    @(negedge clk);
    cfg_we = 1'b1; cfg_x_mode = x; cfg_y_mode = y;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [31:0] a, input logic [1:0] t);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_tiling = t;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  function automatic string tag_of(input logic [2:0] x, input logic [2:0] y, input logic [1:0] t);
    logic [2:0] m;
    m = (t == 2'd1) ? x : (t == 2'd2) ? y : 3'd0;
    if (t == 2'd3) return "R7 invalid tiling";
    if (t == 2'd0) return "R3 untiled";
    if (m == 3'd5) return "R5 unknown mode";
    if (m >= 3'd6) return "R6 bit17 hidden";
    return "R1 R2 R4 swizzle";
  endfunction

  initial begin
    repeat (40000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [37:0] e;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset state", {rsp_valid, cfg_x_vis, cfg_y_vis, req_ready}, {1'b0, 3'd0, 3'd0, 1'b1});
    @(negedge clk); rst = 1'b0;

    foreach (VEC[i]) begin
      program_modes(VEC[i][39:37], VEC[i][36:34]);
      send(VEC[i][31:0], VEC[i][33:32]);
      e = expect_of(VEC[i][39:37], VEC[i][36:34], VEC[i][33:32], VEC[i][31:0]);
      check(tag_of(VEC[i][39:37], VEC[i][36:34], VEC[i][33:32]),
            {rsp_valid, rsp_addr, rsp_tiling, rsp_swz, rsp_err}, {1'b1, e});
    end

    program_modes(3'd7, 3'd6);
    check("R6 status view", {cfg_x_vis, cfg_y_vis}, {3'd2, 3'd1});

    // R10: write and request on the same edge; old X mode (7) applies
    @(negedge clk);
    cfg_we = 1'b1; cfg_x_mode = 3'd0; cfg_y_mode = 3'd0;
    req_valid = 1'b1; req_addr = 32'h0000_0200; req_tiling = 2'd1;
    @(posedge clk); #1;
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R10 old mode on write edge", {rsp_addr, rsp_swz}, {32'h0000_0240, 3'd2});
    send(32'h0000_0200, 2'd1);
    check("R10 new mode after write", {rsp_addr, rsp_swz}, {32'h0000_0200, 3'd0});

    // R8: back-pressure
    program_modes(3'd1, 3'd1);
    @(negedge clk); rsp_ready = 1'b0;
    send(32'h0000_0200, 2'd1);
    check("R8 response one cycle later", {rsp_valid, rsp_addr}, {1'b1, 32'h0000_0240});
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0000_0240; req_tiling = 2'd2;
    #1;
    check("R8 ready low while stalled", {31'd0, req_ready}, 64'd0);
    @(posedge clk); #1;
    check("R8 response held", {rsp_valid, rsp_addr}, {1'b1, 32'h0000_0240});
    @(negedge clk); rsp_ready = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    check("R8 second request after release", {rsp_valid, rsp_addr, rsp_tiling}, {1'b1, 32'h0000_0200, 2'd2});
    @(posedge clk); #1;
    check("R8 valid drops when drained", {63'd0, rsp_valid}, 64'd0);

    // R9: reset mid-run clears programmed modes
    program_modes(3'd4, 3'd4);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R9 reset clears modes", {rsp_valid, cfg_x_vis, cfg_y_vis}, {1'b0, 3'd0, 3'd0});
    @(negedge clk); rst = 1'b0;
    send(32'h0000_0E00, 2'd2);
    check("R9 no swizzle after reset", {rsp_addr, rsp_swz}, {32'h0000_0E00, 3'd0});

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule